// File: doc/BRIEF.md
# Dual-Mode Serial Result Shifter

This block is the serial output stage of a 16-bit converter. A finished conversion word is stored through a parallel load port. The word leaves on a single data pin, most significant bit first. The host picks one of two output codings, straight binary or two's complement. Two's complement here means straight binary with the top bit inverted.

The block has two clocking modes, chosen by `mode_ext`.

- **External-clock mode.** The host drives the shift clock. A read is opened in either of two ways: read/convert rises while chip select is low, or chip select falls while read/convert is high. Opening a read reloads the shifter and arms a one-clock sync pulse. Each falling edge of the host clock advances the data by one bit. After the sixteenth bit, the bits taken from the tag input come out, sixteen clocks late, so that several shifters can be chained on one line.
- **Internal-clock mode.** A convert command makes the block drive sixteen shift-clock pulses of its own. These pulses carry the word from the previous conversion. Between transfers the clock pin stays low. Between transfers the data pin holds the tag level that was captured when the command arrived.

The shift-clock pin is modelled as three signals: an input, an output and an output enable. The host clock is brought into the system clock domain by a synchroniser of `SYNC_STAGES` flops. Chip select, read/convert, the tag input and the selects are expected to be synchronous to `clk`. `HALF_CYC` sets the length of each half of a generated pulse, in system clock cycles, and must be 2 or more.

Top module: `serial_result_shifter`

## Requirements
- R1: When a transfer is loaded, the word is coded with the `fmt_straight` value present at that moment. A value of 1 sends the stored word unchanged. A value of 0 sends it with bit 15 inverted and bits 14..0 unchanged.
- R2: In external mode, a read event puts bit 15 of the coded word on `data_out`. Each synchronised falling edge of `sclk_in` then moves to the next lower bit, while `cs_n`=0 and `rd_cnv`=1. The host samples on the rising edges.
- R3: In external mode, the `tag_in` value sampled at the k-th falling edge after a read appears on `data_out` before rising edge k+16.
- R4: In external mode, a read event is either of two things: `rd_cnv` rising while `cs_n`=0, or `cs_n` falling while `rd_cnv`=1. A read event reloads the shifter and arms `sync_out`. `sync_out` goes high after the next synchronised rising edge of `sclk_in` and low after the following falling edge.
- R5: In external mode, edges on `sclk_in` while `cs_n`=1 or `rd_cnv`=0 do not move `data_out`.
- R6: In internal mode, a convert command sends the word that was stored before the command as exactly 16 pulses on `sclk_out`. A convert command is the first cycle in which `cs_n` and `rd_cnv` are both low. Each pulse is high for `HALF_CYC` cycles, and bits go MSB first.
- R7: `sclk_oe` is 1 in internal mode and 0 in external mode. `sclk_out` is low whenever no internal transfer is running.
- R8: In internal mode, when no transfer is running, `data_out` equals the `tag_in` value sampled with the convert command that started the last transfer.
- R9: A convert command that arrives while an internal transfer is running is ignored. The running transfer still ends after 16 pulses.
- R10: In internal mode, `data_out` never changes in the same cycle as an edge of `sclk_out`. It is therefore stable around both edges of every pulse.
- R11: After reset, `data_out`, `sclk_out` and `sync_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_valid | input | 1 | Stores `load_data` as the latest result |
| load_data | input | RES_W | Parallel conversion result |
| mode_ext | input | 1 | 1 = host-driven shift clock, 0 = internally generated clock |
| fmt_straight | input | 1 | 1 = straight binary, 0 = two's complement |
| cs_n | input | 1 | Chip select, active low |
| rd_cnv | input | 1 | Read (high) / convert (low) |
| tag_in | input | 1 | Daisy-chain and idle level input |
| sclk_in | input | 1 | Shift clock from the host (external mode) |
| sclk_out | output | 1 | Generated shift clock (internal mode) |
| sclk_oe | output | 1 | Drive enable for the shift-clock pin |
| data_out | output | 1 | Serial data |
| sync_out | output | 1 | Read-start sync pulse (external mode) |

## Verification
The main function is exercised with an asymmetric word in each coding. Sending the same word straight and inverted separates a missing or misplaced MSB inversion from an error in bit order.

In external mode, an irregular tag pattern follows the word. It confirms both the sixteen-clock delay and that the first tag bit is the one taken at the first falling edge. A second read is opened by the read/convert edge instead of the chip-select edge. During that read, clocks are sent while the chip is deselected, which separates shifting that is correctly gated from shifting on every edge.

In internal mode, a second convert command is sent in the middle of a transfer, and the tag input is changed after each command. These show whether the transfer restarts and whether the idle level is captured at the right moment. Reloading the result during a transfer shows that the word already in flight is sent.

// File: rtl/srs_pkg.sv
package srs_pkg;

  typedef enum logic {
    CLK_INTERNAL = 1'b0,
    CLK_EXTERNAL = 1'b1
  } clk_mode_e;

  typedef struct packed {
    logic conv;
    logic read;
  } cmd_ev_t;

endpackage

// File: rtl/srs_edge_sync.sv
module srs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] chain_q, chain_n;
  logic              last_q;

  always_comb begin
    chain_n = {chain_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_n;
      last_q  <= chain_q[STAGES-1];
    end
  end

  assign rise_o = chain_q[STAGES-1] & ~last_q;
  assign fall_o = ~chain_q[STAGES-1] & last_q;

endmodule

// File: rtl/srs_cmd_decode.sv
module srs_cmd_decode
  import srs_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cs_n,
  input  logic    rd_cnv,
  output cmd_ev_t ev_o
);

  logic cs_n_q, rd_q;
  logic read_now, read_before, conv_now, conv_before;

  always_comb begin
    read_now    = ~cs_n & rd_cnv;
    read_before = ~cs_n_q & rd_q;
    conv_now    = ~(cs_n | rd_cnv);
    conv_before = ~(cs_n_q | rd_q);
    ev_o.read   = read_now & ~read_before;
    ev_o.conv   = conv_now & ~conv_before;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n_q <= 1'b1;
      rd_q   <= 1'b1;
    end else begin
      cs_n_q <= cs_n;
      rd_q   <= rd_cnv;
    end
  end

endmodule

// File: rtl/srs_int_clock.sv
module srs_int_clock #(
  parameter int RES_W    = 16,
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  output logic active_o,
  output logic sclk_o,
  output logic shift_o
);

  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BW = $clog2(RES_W + 1);

  logic          active_q, active_n;
  logic          phase_q, phase_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [BW-1:0] bits_q, bits_n;
  logic          slot0;

  assign slot0 = active_q & ~phase_q & (cnt_q == '0);

  always_comb begin
    active_n = active_q;
    phase_n  = phase_q;
    cnt_n    = cnt_q;
    bits_n   = bits_q;
    if (!active_q) begin
      if (start && enable) begin
        active_n = 1'b1;
        phase_n  = 1'b0;
        cnt_n    = '0;
        bits_n   = '0;
      end
    end else if (!enable) begin
      active_n = 1'b0;
      phase_n  = 1'b0;
      cnt_n    = '0;
      bits_n   = '0;
    end else if (slot0 && bits_q == BW'(RES_W)) begin
      active_n = 1'b0;
      bits_n   = '0;
    end else if (cnt_q == CW'(HALF_CYC - 1)) begin
      cnt_n   = '0;
      phase_n = ~phase_q;
      if (phase_q) bits_n = bits_q + 1'b1;
    end else begin
      cnt_n = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      cnt_q    <= '0;
      bits_q   <= '0;
    end else begin
      active_q <= active_n;
      phase_q  <= phase_n;
      cnt_q    <= cnt_n;
      bits_q   <= bits_n;
    end
  end

  assign active_o = active_q;
  assign sclk_o   = active_q & phase_q;
  assign shift_o  = slot0 & (bits_q != '0) & (bits_q != BW'(RES_W));

  // R9: once running, the pulse count only moves forward
  p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && $past(active_q)) |-> (bits_q >= $past(bits_q)));

  // R6: no pulse is started after the last data bit
  p_pulse_limit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && phase_q) |-> (bits_q < BW'(RES_W)));

endmodule

// File: rtl/serial_result_shifter.sv
module serial_result_shifter
  import srs_pkg::*;
#(
  parameter int RES_W       = 16,
  parameter int HALF_CYC    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_valid,
  input  logic [RES_W-1:0] load_data,
  input  logic             mode_ext,
  input  logic             fmt_straight,
  input  logic             cs_n,
  input  logic             rd_cnv,
  input  logic             tag_in,
  input  logic             sclk_in,
  output logic             sclk_out,
  output logic             sclk_oe,
  output logic             data_out,
  output logic             sync_out
);

  localparam int MSB = RES_W - 1;

  clk_mode_e   mode;
  cmd_ev_t     ev;
  logic        ext_rise, ext_fall;
  logic        ic_active, ic_sclk, ic_shift, conv_go;
  logic        ext_shift;
  logic [MSB:0] result_q, result_n;
  logic [MSB:0] shreg_q, shreg_n;
  logic [MSB:0] coded;
  logic        tag_hold_q, tag_hold_n;
  logic        arm_q, arm_n, sync_q, sync_n;

  assign mode = clk_mode_e'(mode_ext);

  srs_edge_sync #(.STAGES(SYNC_STAGES)) u_sclk_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (sclk_in),
    .rise_o   (ext_rise),
    .fall_o   (ext_fall)
  );

  srs_cmd_decode u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .rd_cnv (rd_cnv),
    .ev_o   (ev)
  );

  assign conv_go = ev.conv & (mode == CLK_INTERNAL) & ~ic_active;

  srs_int_clock #(.RES_W(RES_W), .HALF_CYC(HALF_CYC)) u_int_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (mode == CLK_INTERNAL),
    .start    (conv_go),
    .active_o (ic_active),
    .sclk_o   (ic_sclk),
    .shift_o  (ic_shift)
  );

  // Output coding: two's complement is straight binary with the top bit flipped
  always_comb begin
    coded      = result_q;
    coded[MSB] = result_q[MSB] ^ ~fmt_straight;
  end

  assign ext_shift = (mode == CLK_EXTERNAL) & ext_fall & ~cs_n & rd_cnv;

  always_comb begin
    result_n   = load_valid ? load_data : result_q;
    tag_hold_n = conv_go ? tag_in : tag_hold_q;
    shreg_n    = shreg_q;
    if ((mode == CLK_EXTERNAL) && ev.read)
      shreg_n = coded;
    else if (conv_go)
      shreg_n = coded;
    else if (ext_shift)
      shreg_n = {shreg_q[MSB-1:0], tag_in};
    else if ((mode == CLK_INTERNAL) && ic_shift)
      shreg_n = {shreg_q[MSB-1:0], tag_hold_q};
  end

  always_comb begin
    arm_n  = arm_q;
    sync_n = sync_q;
    if (mode == CLK_INTERNAL) begin
      arm_n  = 1'b0;
      sync_n = 1'b0;
    end else begin
      if (ext_rise && arm_q) begin
        sync_n = 1'b1;
        arm_n  = 1'b0;
      end else if (ext_fall) begin
        sync_n = 1'b0;
      end
      if (ev.read) arm_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q   <= '0;
      shreg_q    <= '0;
      tag_hold_q <= 1'b0;
      arm_q      <= 1'b0;
      sync_q     <= 1'b0;
    end else begin
      result_q   <= result_n;
      shreg_q    <= shreg_n;
      tag_hold_q <= tag_hold_n;
      arm_q      <= arm_n;
      sync_q     <= sync_n;
    end
  end

  assign data_out = ((mode == CLK_EXTERNAL) || ic_active) ? shreg_q[MSB] : tag_hold_q;
  assign sclk_out = ic_sclk;
  assign sclk_oe  = (mode == CLK_INTERNAL);
  assign sync_out = sync_q;

  // R10: data holds across every edge of the generated clock
  p_data_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ext && !$stable(sclk_out)) |-> $stable(data_out));

  // R4: a sync pulse only begins in external mode
  p_sync_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> $past(mode_ext));

  // R4: the pulse ends at the next host falling edge
  p_sync_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_out && ext_fall && mode_ext) |=> !sync_out);

  // R7: the generated clock stays quiet once the pin is an input
  p_quiet_input_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!sclk_oe && !$past(sclk_oe)) |-> !sclk_out);

endmodule

// File: tb/tb_serial_result_shifter.sv
`timescale 1ns/1ps
module tb_serial_result_shifter;

  localparam int RES_W = 16;
  localparam int HALF  = 2;
  localparam int EXT_H = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             load_valid, mode_ext, fmt_straight, cs_n, rd_cnv, tag_in, sclk_in;
  logic [RES_W-1:0] load_data;
  logic             sclk_out, sclk_oe, data_out, sync_out;

  int n_checks = 0;
  int n_errors = 0;
  bit    exp_bit[$];
  string exp_req[$];
  int pulses = 0, hi_run = 0, last_hi = 0;
  logic prev_out = 1'b0, prev_in = 1'b0;

  always #4 clk = ~clk;

  serial_result_shifter #(.RES_W(RES_W), .HALF_CYC(HALF), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .load_valid(load_valid), .load_data(load_data),
    .mode_ext(mode_ext), .fmt_straight(fmt_straight), .cs_n(cs_n), .rd_cnv(rd_cnv),
    .tag_in(tag_in), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .data_out(data_out), .sync_out(sync_out)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [RES_W-1:0] code(input logic [RES_W-1:0] w, input bit sb);
    code = w;
    if (!sb) code[RES_W-1] = ~w[RES_W-1];
  endfunction

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push_bits(input logic [RES_W-1:0] w, input int count, input string req);
    for (int i = RES_W - 1; i >= RES_W - count; i--) begin
      exp_bit.push_back(w[i]);
      exp_req.push_back(req);
    end
  endtask

  task automatic load(input logic [RES_W-1:0] w);
    load_valid = 1'b1;
    load_data  = w;
    tick(1);
    load_valid = 1'b0;
  endtask

  task automatic pop_compare(input string where);
    if (exp_bit.size() == 0) begin
      check({where, " unexpected bit"}, 1, 0);
    end else begin
      automatic bit    e = exp_bit.pop_front();
      automatic string r = exp_req.pop_front();
      check(r, data_out, e);
    end
  endtask

  // Monitor: compares the serial line against the scoreboard at each rising edge
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      if (!mode_ext) begin
        if (sclk_out && !prev_out) begin
          pulses++;
          hi_run = 0;
          pop_compare("R6");
        end
        if (sclk_out) hi_run++;
        if (!sclk_out && prev_out) last_hi = hi_run;
      end else if (sclk_in && !prev_in && !cs_n && rd_cnv) begin
        pop_compare("R2");
      end
    end
    prev_out = sclk_out;
    prev_in  = sclk_in;
  end

  initial begin
    #(8 * 200000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [RES_W-1:0] wa, wb, wc;
    bit pat [4];
    wa = 16'hA5C3;
    wb = 16'h1E69;
    wc = 16'h3C5A;
    pat[0] = 1'b1; pat[1] = 1'b0; pat[2] = 1'b0; pat[3] = 1'b1;
    rst_n = 1'b0; load_valid = 1'b0; load_data = '0; mode_ext = 1'b0;
    fmt_straight = 1'b1; cs_n = 1'b1; rd_cnv = 1'b1; tag_in = 1'b0; sclk_in = 1'b0;
    tick(4);
    rst_n = 1'b1;
    tick(2);
    check("R11 data", data_out, 0);
    check("R11 sclk", sclk_out, 0);
    check("R11 sync", sync_out, 0);
    check("R7 oe internal", sclk_oe, 1);

    // Internal mode, straight binary, result reloaded mid-transfer
    load(wa);
    cs_n = 1'b0;
    tick(2);
    tag_in = 1'b1;
    pulses = 0;
    push_bits(code(wa, 1'b1), RES_W, "R6");
    rd_cnv = 1'b0;
    tick(1);
    tag_in = 1'b0;
    tick(10);
    load(wb);
    tick(80);
    check("R6 pulse count", pulses, 16);
    check("R6 high width", last_hi, HALF);
    check("R6 all bits sent", exp_bit.size(), 0);
    check("R8 idle tag", data_out, 1);
    check("R7 idle low", sclk_out, 0);
    rd_cnv = 1'b1;
    tick(3);

    // Internal mode, two's complement, second command mid-transfer
    fmt_straight = 1'b0;
    tag_in = 1'b0;
    pulses = 0;
    push_bits(code(wb, 1'b0), RES_W, "R1");
    rd_cnv = 1'b0;
    tick(1);
    tag_in = 1'b1;
    tick(20);
    rd_cnv = 1'b1;
    tick(2);
    rd_cnv = 1'b0;
    tick(80);
    check("R9 pulse count", pulses, 16);
    check("R9 queue drained", exp_bit.size(), 0);
    check("R8 idle tag low", data_out, 0);
    check("R7 idle low", sclk_out, 0);

    // External mode, read opened by chip select falling
    rd_cnv = 1'b1;
    cs_n = 1'b1;
    mode_ext = 1'b1;
    fmt_straight = 1'b1;
    tick(4);
    check("R7 oe external", sclk_oe, 0);
    check("R7 sclk external", sclk_out, 0);
    load(wc);
    cs_n = 1'b0;
    tick(EXT_H);
    check("R4 sync before edge", sync_out, 0);
    push_bits(code(wc, 1'b1), RES_W, "R2");
    for (int k = 0; k < 4; k++) begin
      exp_bit.push_back(pat[k]);
      exp_req.push_back("R3");
    end
    for (int k = 0; k < 20; k++) begin
      sclk_in = 1'b1;
      tag_in = (k < 4) ? pat[k] : 1'b0;
      tick(6);
      if (k == 0) check("R4 sync high", sync_out, 1);
      tick(EXT_H - 6);
      sclk_in = 1'b0;
      tick(6);
      if (k == 0) check("R4 sync low", sync_out, 0);
      tick(EXT_H - 6);
    end
    check("R3 queue drained", exp_bit.size(), 0);

    // External mode, read opened by read/convert rising, then deselected clocks
    rd_cnv = 1'b0;
    tick(2);
    fmt_straight = 1'b0;
    rd_cnv = 1'b1;
    tick(EXT_H);
    push_bits(code(wc, 1'b0), 4, "R4");
    for (int k = 0; k < 4; k++) begin
      sclk_in = 1'b1; tag_in = 1'b0; tick(EXT_H);
      sclk_in = 1'b0; tick(EXT_H);
    end
    cs_n = 1'b1;
    tick(4);
    for (int k = 0; k < 3; k++) begin
      sclk_in = 1'b1; tick(EXT_H);
      sclk_in = 1'b0; tick(EXT_H);
    end
    begin
      automatic logic [RES_W-1:0] cw = code(wc, 1'b0);
      check("R5 frozen", data_out, cw[RES_W-5]);
    end
    check("R4 queue drained", exp_bit.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule